// File: doc/BRIEF.md
# Assigned-Signature Control Flow Checker

This block watches the control flow of software running on one or more checked processors. At each basic block the program writes a statement label to the checker. The label is made of three 8-bit sublabels, and the write also carries a 4-bit process number and a 4-bit processor number. The checker keeps the last accepted label of every process as that process's reference. A new label is legal when at least one of its sublabels equals some reference sublabel plus one, modulo 256. This is a 3×3 compare, resolved in the cycle the label arrives. No graph or table of allowed sequences is stored.

Each of the 16 processes has a small state machine with three states. `S_IDLE` means not monitored. `S_FIRST` means armed and waiting for its first label. `S_RUN` means checking. The transitions are:
- *arm*: any state to `S_FIRST`.
- *stop*: any state to `S_IDLE`.
- *load*: `S_FIRST` to `S_RUN` on the first label.
- *advance*: `S_RUN` to itself on a legal label, which replaces the reference.

A label that fails the check leaves the reference unchanged. It drives the error state machine from `E_CLEAR` to `E_HELD` (*capture*), which records the process, processor and label. The machine returns to `E_CLEAR` on *clear*. A second machine of the same type holds the time-out error. It is set when an armed process has gone `tmo_limit` cycles without sending a label.

Top module: `cfsig_checker`

## Requirements
- R1: After reset every process is in `S_IDLE`, and `flow_err` and `tmo_err` are low.
- R2: The first label a process sends after being armed (`ctl_valid` with `ctl_stop`=0) is accepted without comparison and becomes its reference.
- R3: A label from a process in `S_RUN` is legal if any sublabel `label[8k+7:8k]` (k=0..2) equals `(ref[8j+7:8j]+1) mod 256` for any j. A legal label becomes the new reference. Example: reference (2,5,2) accepts (6,13,6).
- R4: The successor wraps, so 255 is followed by 0.
- R5: Every process checks against its own reference, selected by `sig_pid`. A label that is legal for one process is rejected when it is sent under another process whose reference does not fit.
- R6: A rejected label sets `flow_err` on the following clock edge and does not change the reference.
- R7: `flow_err` is sticky. `err_pid`, `err_cpu` and `err_label` keep the first failing signature until a clear, and later errors do not overwrite them.
- R8: `err_clr` drops `flow_err` and `tmo_err` on the next edge. An error that is new in the same cycle wins over the clear.
- R9: A label sent for a process in `S_IDLE` is ignored and raises no error.
- R10: `sig_ready` is low in any cycle where `ctl_valid` is high, and high otherwise.
- R11: If an armed process sends no label for `tmo_limit` cycles, `tmo_err` rises one cycle later and `tmo_pid` gives the lowest such process. The flag is sticky.
- R12: A label from a process, or an arm or stop command for it, reloads that process's time-out counter. A process in `S_IDLE` never times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_valid | input | 1 | Arm or stop command for one process |
| ctl_stop | input | 1 | 1 = stop (disarm), 0 = arm |
| ctl_pid | input | 4 | Process addressed by the command |
| tmo_limit | input | 16 | Time-out interval in cycles, nonzero |
| err_clr | input | 1 | Clears both error flags |
| sig_valid | input | 1 | Signature offered |
| sig_ready | output | 1 | Signature can be taken this cycle |
| sig_pid | input | 4 | Process number of the signature |
| sig_cpu | input | 4 | Processor number of the signature |
| sig_label | input | 24 | Three 8-bit sublabels |
| flow_err | output | 1 | Sticky illegal-successor flag |
| err_pid | output | 4 | Process of the first illegal label |
| err_cpu | output | 4 | Processor of the first illegal label |
| err_label | output | 24 | First illegal label |
| tmo_err | output | 1 | Sticky time-out flag |
| tmo_pid | output | 4 | Process that timed out |

## Verification
A corrupted reference register shows up on the next label from that process. The label is then rejected, and `flow_err` rises one edge later with the failing label captured. A process state machine stuck in the wrong state shows up as a first label that is rejected, or a label for an idle process that is flagged. A broken time-out counter moves the rise of `tmo_err` away from exactly `tmo_limit`+1 cycles after the last reload, so the bench samples on either side of that edge.

// File: rtl/cfsig_pkg.sv
package cfsig_pkg;
    localparam int unsigned NSUB = 3;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FIRST = 2'd1,
        S_RUN   = 2'd2
    } slot_st_t;

    typedef enum logic {
        E_CLEAR = 1'b0,
        E_HELD  = 1'b1
    } err_st_t;
endpackage

// File: rtl/cfsig_match.sv
module cfsig_match #(
    parameter int unsigned SUB_W = 8,
    parameter int unsigned NSUB  = 3,
    localparam int unsigned LBL_W = SUB_W * NSUB
) (
    input  logic [LBL_W-1:0] ref_label,
    input  logic [LBL_W-1:0] new_label,
    output logic             is_succ
);
    logic [NSUB*NSUB-1:0] hit;

    for (genvar j = 0; j < NSUB; j++) begin : g_ref
        logic [SUB_W-1:0] nxt;
        assign nxt = ref_label[j*SUB_W +: SUB_W] + SUB_W'(1);
        for (genvar k = 0; k < NSUB; k++) begin : g_new
            assign hit[j*NSUB + k] = (new_label[k*SUB_W +: SUB_W] == nxt);
        end
    end

    assign is_succ = |hit;
endmodule

// File: rtl/cfsig_slot.sv
module cfsig_slot
    import cfsig_pkg::*;
#(
    parameter int unsigned LBL_W = 24,
    parameter int unsigned TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             stop,
    input  logic             seen,
    input  logic             load,
    input  logic [LBL_W-1:0] load_label,
    input  logic [TMO_W-1:0] tmo_limit,
    output slot_st_t         st,
    output logic [LBL_W-1:0] ref_label,
    output logic             expired
);
    slot_st_t         st_q, st_d;
    logic [TMO_W-1:0] cnt_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (arm) st_d = S_FIRST;
            S_FIRST: if (stop) st_d = S_IDLE;
                     else if (arm) st_d = S_FIRST;
                     else if (load) st_d = S_RUN;
            S_RUN:   if (stop) st_d = S_IDLE;
                     else if (arm) st_d = S_FIRST;
            default: st_d = S_IDLE;
        endcase
        if (st_q == S_IDLE && stop) st_d = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_label <= '0;
            cnt_q     <= '0;
        end else begin
            if (load) ref_label <= load_label;
            if (arm || stop || seen)
                cnt_q <= '0;
            else if (st_q != S_IDLE && cnt_q < tmo_limit)
                cnt_q <= cnt_q + TMO_W'(1);
        end
    end

    assign st      = st_q;
    assign expired = (st_q != S_IDLE) && (cnt_q >= tmo_limit);
endmodule

// File: rtl/cfsig_errhold.sv
module cfsig_errhold
    import cfsig_pkg::*;
#(
    parameter int unsigned NPROC = 16,
    parameter int unsigned CPU_W = 4,
    parameter int unsigned LBL_W = 24,
    localparam int unsigned PID_W = $clog2(NPROC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bad,
    input  logic [PID_W-1:0] bad_pid,
    input  logic [CPU_W-1:0] bad_cpu,
    input  logic [LBL_W-1:0] bad_label,
    input  logic [NPROC-1:0] exp_v,
    output logic             flow_err,
    output logic [PID_W-1:0] err_pid,
    output logic [CPU_W-1:0] err_cpu,
    output logic [LBL_W-1:0] err_label,
    output logic             tmo_err,
    output logic [PID_W-1:0] tmo_pid
);
    err_st_t          fst_q, fst_d, tst_q, tst_d;
    logic [PID_W-1:0] first_exp;
    logic             any_exp;
    logic             f_cap, t_cap;

    always_comb begin
        first_exp = '0;
        for (int i = NPROC - 1; i >= 0; i--)
            if (exp_v[i]) first_exp = PID_W'(i);
        any_exp = |exp_v;
    end

    always_comb begin
        fst_d = fst_q;
        f_cap = 1'b0;
        unique case (fst_q)
            E_CLEAR: if (bad) begin fst_d = E_HELD; f_cap = 1'b1; end
            E_HELD:  if (clr && bad) f_cap = 1'b1;
                     else if (clr) fst_d = E_CLEAR;
            default: fst_d = E_CLEAR;
        endcase
        tst_d = tst_q;
        t_cap = 1'b0;
        unique case (tst_q)
            E_CLEAR: if (any_exp) begin tst_d = E_HELD; t_cap = 1'b1; end
            E_HELD:  if (clr && any_exp) t_cap = 1'b1;
                     else if (clr) tst_d = E_CLEAR;
            default: tst_d = E_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fst_q <= E_CLEAR;
            tst_q <= E_CLEAR;
        end else begin
            fst_q <= fst_d;
            tst_q <= tst_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_pid   <= '0;
            err_cpu   <= '0;
            err_label <= '0;
            tmo_pid   <= '0;
        end else begin
            if (f_cap) begin
                err_pid   <= bad_pid;
                err_cpu   <= bad_cpu;
                err_label <= bad_label;
            end
            if (t_cap) tmo_pid <= first_exp;
        end
    end

    assign flow_err = (fst_q == E_HELD);
    assign tmo_err  = (tst_q == E_HELD);
endmodule

// File: rtl/cfsig_checker.sv
module cfsig_checker
    import cfsig_pkg::*;
#(
    parameter int unsigned NPROC = 16,
    parameter int unsigned CPU_W = 4,
    parameter int unsigned SUB_W = 8,
    parameter int unsigned TMO_W = 16,
    localparam int unsigned PID_W = $clog2(NPROC),
    localparam int unsigned LBL_W = SUB_W * NSUB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_valid,
    input  logic             ctl_stop,
    input  logic [PID_W-1:0] ctl_pid,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             err_clr,
    input  logic             sig_valid,
    output logic             sig_ready,
    input  logic [PID_W-1:0] sig_pid,
    input  logic [CPU_W-1:0] sig_cpu,
    input  logic [LBL_W-1:0] sig_label,
    output logic             flow_err,
    output logic [PID_W-1:0] err_pid,
    output logic [CPU_W-1:0] err_cpu,
    output logic [LBL_W-1:0] err_label,
    output logic             tmo_err,
    output logic [PID_W-1:0] tmo_pid
);
    slot_st_t         st_v  [NPROC];
    logic [LBL_W-1:0] ref_v [NPROC];
    logic [NPROC-1:0] exp_v;
    slot_st_t         sel_st;
    logic [LBL_W-1:0] sel_ref;
    logic             fire, is_succ, chk_bad, load_sel;

    assign sig_ready = !ctl_valid;
    assign fire      = sig_valid && sig_ready;
    assign sel_st    = st_v[sig_pid];
    assign sel_ref   = ref_v[sig_pid];

    cfsig_match #(.SUB_W(SUB_W), .NSUB(NSUB)) u_match (
        .ref_label (sel_ref),
        .new_label (sig_label),
        .is_succ   (is_succ)
    );

    assign chk_bad  = fire && (sel_st == S_RUN) && !is_succ;
    assign load_sel = fire && ((sel_st == S_FIRST) || ((sel_st == S_RUN) && is_succ));

    for (genvar i = 0; i < NPROC; i++) begin : g_slot
        logic hit_ctl, hit_sig;
        assign hit_ctl = ctl_valid && (ctl_pid == PID_W'(i));
        assign hit_sig = fire && (sig_pid == PID_W'(i));
        cfsig_slot #(.LBL_W(LBL_W), .TMO_W(TMO_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .arm        (hit_ctl && !ctl_stop),
            .stop       (hit_ctl && ctl_stop),
            .seen       (hit_sig),
            .load       (hit_sig && load_sel),
            .load_label (sig_label),
            .tmo_limit  (tmo_limit),
            .st         (st_v[i]),
            .ref_label  (ref_v[i]),
            .expired    (exp_v[i])
        );
    end

    cfsig_errhold #(.NPROC(NPROC), .CPU_W(CPU_W), .LBL_W(LBL_W)) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (err_clr),
        .bad       (chk_bad),
        .bad_pid   (sig_pid),
        .bad_cpu   (sig_cpu),
        .bad_label (sig_label),
        .exp_v     (exp_v),
        .flow_err  (flow_err),
        .err_pid   (err_pid),
        .err_cpu   (err_cpu),
        .err_label (err_label),
        .tmo_err   (tmo_err),
        .tmo_pid   (tmo_pid)
    );
endmodule

// File: rtl/cfsig_checker_sva.sv
module cfsig_checker_sva #(
    parameter int unsigned PID_W = 4,
    parameter int unsigned CPU_W = 4,
    parameter int unsigned LBL_W = 24,
    parameter int unsigned NPROC = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_valid,
    input logic             err_clr,
    input logic             sig_ready,
    input logic             chk_bad,
    input logic [NPROC-1:0] exp_v,
    input logic             flow_err,
    input logic [PID_W-1:0] err_pid,
    input logic [CPU_W-1:0] err_cpu,
    input logic [LBL_W-1:0] err_label,
    input logic             tmo_err
);
    p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_valid |-> !sig_ready);

    p_bad_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_bad |=> flow_err);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flow_err && !err_clr |=> flow_err);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flow_err && !err_clr |=> $stable(err_pid) && $stable(err_cpu) && $stable(err_label));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !chk_bad |=> !flow_err);

    p_tmo_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err && !err_clr |=> tmo_err);

    p_tmo_raise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|exp_v) |=> tmo_err);
endmodule

bind cfsig_checker cfsig_checker_sva #(
    .PID_W(PID_W), .CPU_W(CPU_W), .LBL_W(LBL_W), .NPROC(NPROC)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_valid (ctl_valid),
    .err_clr   (err_clr),
    .sig_ready (sig_ready),
    .chk_bad   (chk_bad),
    .exp_v     (exp_v),
    .flow_err  (flow_err),
    .err_pid   (err_pid),
    .err_cpu   (err_cpu),
    .err_label (err_label),
    .tmo_err   (tmo_err)
);

// File: tb/cfsig_checker_tb.sv
module cfsig_checker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_valid = 1'b0, ctl_stop = 1'b0, err_clr = 1'b0, sig_valid = 1'b0;
    logic [3:0]  ctl_pid = '0, sig_pid = '0, sig_cpu = '0;
    logic [15:0] tmo_limit = 16'hFFFF;
    logic [23:0] sig_label = '0;
    logic        sig_ready, flow_err, tmo_err;
    logic [3:0]  err_pid, err_cpu, tmo_pid;
    logic [23:0] err_label;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    int          m_st  [16];
    logic [23:0] m_ref [16];
    bit          m_ferr = 1'b0;
    logic [3:0]  m_epid = '0, m_ecpu = '0;
    logic [23:0] m_elab = '0;

    always #4 clk = ~clk;

    cfsig_checker u_dut (.*);

    function automatic logic [23:0] mk(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        return {c, b, a};
    endfunction

    function automatic bit succ_ok(input logic [23:0] r, input logic [23:0] n);
        for (int j = 0; j < 3; j++)
            for (int k = 0; k < 3; k++)
                if (n[8*k +: 8] == 8'(r[8*j +: 8] + 8'd1)) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        chk(flow_err == m_ferr, tag, 32'(flow_err), 32'(m_ferr));
        if (m_ferr) begin
            chk(err_pid == m_epid, tag, 32'(err_pid), 32'(m_epid));
            chk(err_cpu == m_ecpu, tag, 32'(err_cpu), 32'(m_ecpu));
            chk(err_label == m_elab, tag, 32'(err_label), 32'(m_elab));
        end
    endtask

    task automatic do_ctl(input bit stop, input logic [3:0] pid);
        @(negedge clk);
        ctl_valid = 1'b1; ctl_stop = stop; ctl_pid = pid; sig_valid = 1'b1;
        #1 chk(sig_ready == 1'b0, "R10 ready low on ctl", 32'(sig_ready), 0);
        @(negedge clk);
        ctl_valid = 1'b0; sig_valid = 1'b0;
        m_st[pid] = stop ? 0 : 1;
    endtask

    task automatic do_sig(input logic [3:0] pid, input logic [3:0] cpu, input logic [23:0] lab);
        @(negedge clk);
        sig_valid = 1'b1; sig_pid = pid; sig_cpu = cpu; sig_label = lab;
        #1 chk(sig_ready == 1'b1, "R10 ready high", 32'(sig_ready), 1);
        @(negedge clk);
        sig_valid = 1'b0;
        if (m_st[pid] == 1) begin
            m_ref[pid] = lab; m_st[pid] = 2;
        end else if (m_st[pid] == 2) begin
            if (succ_ok(m_ref[pid], lab)) m_ref[pid] = lab;
            else if (!m_ferr) begin
                m_ferr = 1'b1; m_epid = pid; m_ecpu = cpu; m_elab = lab;
            end
        end
    endtask

    task automatic do_clr();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        m_ferr = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 16; i++) begin m_st[i] = 0; m_ref[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(flow_err == 1'b0 && tmo_err == 1'b0, "R1 reset flags", 32'({flow_err, tmo_err}), 0);

        // R9: idle process ignores labels
        do_sig(4'd7, 4'd1, mk(8'd9, 8'd9, 8'd9));
        do_sig(4'd7, 4'd1, mk(8'd50, 8'd60, 8'd70));
        check_state("R9 idle label ignored");

        // R2 + R3 example from the rule
        do_ctl(1'b0, 4'd2);
        do_sig(4'd2, 4'd3, mk(8'd2, 8'd5, 8'd2));
        check_state("R2 first label accepted");
        do_sig(4'd2, 4'd3, mk(8'd6, 8'd13, 8'd6));
        check_state("R3 (2,5,2)->(6,13,6) accepted");

        // R4 wrap
        do_ctl(1'b0, 4'd4);
        do_sig(4'd4, 4'd0, mk(8'd40, 8'd255, 8'd40));
        do_sig(4'd4, 4'd0, mk(8'd50, 8'd50, 8'd0));
        check_state("R4 255 wraps to 0");

        // R5 per-process reference: successor of pid2's ref sent as pid4
        do_sig(4'd4, 4'd9, mk(8'd7, 8'd14, 8'd7));
        check_state("R5 wrong process rejected");
        chk(flow_err == 1'b1 && err_pid == 4'd4 && err_cpu == 4'd9, "R5 capture",
            32'({flow_err, err_pid, err_cpu}), 32'({1'b1, 4'd4, 4'd9}));

        // R7 second error does not overwrite
        do_sig(4'd2, 4'd5, mk(8'd100, 8'd100, 8'd100));
        check_state("R7 first error kept");
        do_clr();
        check_state("R8 clear");

        // R6 reference unchanged after rejection: pid2 ref still (6,13,6)
        do_sig(4'd2, 4'd1, mk(8'd14, 8'd0, 8'd0));
        check_state("R6 ref unchanged after reject");

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            int op = int'($urandom_range(0, 19));
            logic [3:0] p = 4'($urandom_range(0, 15));
            if (op < 2) do_ctl(op == 1, p);
            else if (op == 2) do_clr();
            else begin
                logic [23:0] lab = 24'($urandom);
                if (op < 14 && m_st[p] == 2) begin
                    int j = int'($urandom_range(0, 2));
                    int k = int'($urandom_range(0, 2));
                    lab[8*k +: 8] = 8'(m_ref[p][8*j +: 8] + 8'd1);
                end
                do_sig(p, 4'($urandom_range(0, 15)), lab);
            end
            check_state("R3 random sequence");
            if (n % 100 == 0)
                chk(tmo_err == 1'b0, "R11 no time-out under long limit", 32'(tmo_err), 0);
        end

        // Time-out phase
        for (int i = 0; i < 16; i++) do_ctl(1'b1, 4'(i));
        do_clr();
        tmo_limit = 16'd10;
        do_ctl(1'b0, 4'd5);
        repeat (9) @(negedge clk);
        chk(tmo_err == 1'b0, "R11 not before limit", 32'(tmo_err), 0);
        repeat (3) @(negedge clk);
        chk(tmo_err == 1'b1, "R11 raised after limit", 32'(tmo_err), 1);
        chk(tmo_pid == 4'd5, "R11 tmo_pid", 32'(tmo_pid), 5);
        do_ctl(1'b1, 4'd5);
        do_clr();
        chk(tmo_err == 1'b0, "R8 tmo cleared", 32'(tmo_err), 0);
        repeat (30) @(negedge clk);
        chk(tmo_err == 1'b0, "R12 idle never times out", 32'(tmo_err), 0);

        do_ctl(1'b0, 4'd5);
        for (int r = 0; r < 6; r++) begin
            repeat (6) @(negedge clk);
            do_sig(4'd5, 4'd2, mk(8'(r), 8'(r), 8'(r)));
        end
        chk(tmo_err == 1'b0, "R12 labels reload timer", 32'(tmo_err), 0);
        check_state("R12 labels legal");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule